// File: doc/BRIEF.md
# DRAM Powerdown Self-Refresh Controller

This block holds the power state of a DRAM device and keeps the array refreshed while the device clock is not driven by the host. It has two power states, Active and Powerdown. A powerdown command from the request decoder starts a fixed entry delay, after which the device is in Powerdown. While in Powerdown, a free-running internal timer issues refresh strobes at a fixed interval, each one tagged with a bank index and a row index.

Only one thing brings the device back: a write of the value 0x01 to address 0x03 of the serial configuration port, which sets an internal exit bit. Active is reached a fixed exit delay after that write, and the exit bit clears itself then. The bank and row counters are shared with the refresh commands that the host issues in Active, so no row is skipped across state changes. The bank counter runs through every bank before the row counter moves on.

Top module: `pdn_refresh_ctrl`

## Requirements
- R1: After reset the block is Active (`powerdown_o` = 0), `ref_stb_o` is 0 and both address outputs are 0.
- R2: A `pdn_cmd_i` pulse sampled in Active makes `powerdown_o` rise at the ENTRY_DLY-th clock edge after the sampling edge. A command sampled in any other state is ignored.
- R3: External refresh commands sampled during the entry delay or in Powerdown produce no strobe and leave both counters unchanged.
- R4: In Powerdown, `ref_stb_o` pulses for one cycle every REF_INTERVAL cycles. The first pulse comes REF_INTERVAL cycles after `powerdown_o` rises, and the timer restarts from zero on every entry.
- R5: Each strobe presents the bank and row counter values from before the strobe. The bank counter then advances by one, modulo 2^BANK_W.
- R6: On an automatic refresh, the row counter increments, modulo 2^ROW_W, exactly when the bank counter wraps from all ones to zero.
- R7: In Active, a pulse on `ext_ref_i` gives one strobe on the next cycle at the current address and advances the bank counter. The row counter stays unchanged, even when the bank wraps.
- R8: In Active, a pulse on `ext_ref_inc_i` behaves as in R7, except that the row counter also increments by one.
- R9: In Powerdown, a serial write with address 0x03 and data 0x01 sets the exit bit. `powerdown_o` then falls at the EXIT_DLY-th clock edge after the write's sampling edge.
- R10: A serial write with any other address or data, or any serial write made outside Powerdown, leaves the power state unchanged.
- R11: No refresh strobe is issued between the exit write and the return to Active.
- R12: The exit bit clears when Active is reached. A later powerdown command then enters Powerdown and stays there until a new exit write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pdn_cmd_i | input | 1 | Powerdown command pulse from the request decoder |
| ext_ref_i | input | 1 | External refresh, bank advances only |
| ext_ref_inc_i | input | 1 | External refresh that also increments the row |
| cfg_wr_i | input | 1 | Serial port write strobe, high in the cycle the write ends |
| cfg_addr_i | input | CFG_AW | Serial register address |
| cfg_data_i | input | CFG_DW | Serial register write data |
| ref_stb_o | output | 1 | One-cycle refresh strobe |
| ref_bank_o | output | BANK_W | Bank of the current refresh |
| ref_row_o | output | ROW_W | Row of the current refresh |
| powerdown_o | output | 1 | 1 in Powerdown (including the exit delay), 0 in Active |

## Verification
The bench runs on a reduced configuration of 8 banks and 8 rows. It sweeps more than the full bank-by-row space in Powerdown, so the row counter must wrap exactly once for every eight bank wraps and then come back to zero. A run of plain external refreshes that crosses a bank wrap shows the difference between the two external commands: only the incrementing form moves the row. Refresh commands, a repeated powerdown command and near-miss serial writes are all injected during entry or Powerdown. The strobe spacing and the address sequence then show whether any of them leaked into the timer or the counters. A second entry preceded by an exit write made in Active confirms that the exit bit neither latches outside Powerdown nor stays set after an exit, and that the timer restarts.

// File: rtl/pdn_refresh_pkg.sv
// Shared types and constants for the powerdown self-refresh controller.
// Assumes: every module of the block imports this package.
package pdn_refresh_pkg;

    // Power state: ACTIVE and ENTER report Active, DOWN and EXIT report Powerdown
    typedef enum logic [1:0] {
        PS_ACTIVE = 2'd0,
        PS_ENTER  = 2'd1,
        PS_DOWN   = 2'd2,
        PS_EXIT   = 2'd3
    } pwr_state_e;

    // Serial register that holds the exit bit, and the value that sets it
    localparam int unsigned EXIT_REG_ADDR = 3;
    localparam int unsigned EXIT_REG_VAL  = 1;

endpackage

// File: rtl/pdn_cfg_port.sv
// Serial configuration register decode for the powerdown exit bit.
// Sets the exit bit on a matching write accepted in Powerdown and holds it
// until the state machine reports that Active has been reached.
// Assumes: wr_i is a one-cycle strobe marking the end of a serial write.
module pdn_cfg_port #(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned EXIT_ADDR = 3,
    parameter int unsigned EXIT_VAL  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              in_down_i,
    input  logic              clr_i,
    output logic              px_o
);

    localparam logic [ADDR_W-1:0] MATCH_ADDR = ADDR_W'(EXIT_ADDR);
    localparam logic [DATA_W-1:0] MATCH_DATA = DATA_W'(EXIT_VAL);

    logic hit;

    // Write decode: exact address and data match, accepted only in Powerdown
    always_comb begin
        hit = wr_i && in_down_i && (addr_i == MATCH_ADDR) && (data_i == MATCH_DATA);
    end

    // Exit bit register: clear has priority, set on a matching write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            px_o <= 1'b0;
        end else if (clr_i) begin
            px_o <= 1'b0;
        end else if (hit) begin
            px_o <= 1'b1;
        end
    end

endmodule

// File: rtl/pdn_state_fsm.sv
// Power state sequencer with a shared delay counter for the entry and exit
// delays.
// Assumes: ENTRY_DLY >= 1 and EXIT_DLY >= 2. The exit delay counts from the
// edge that samples the exit write, and the exit bit is seen one edge later.
module pdn_state_fsm
    import pdn_refresh_pkg::*;
#(
    parameter int unsigned ENTRY_DLY = 4,
    parameter int unsigned EXIT_DLY  = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pdn_cmd_i,
    input  logic       px_i,
    output pwr_state_e state_o,
    output logic       px_clr_o
);

    localparam int unsigned CNT_MAX = (ENTRY_DLY > EXIT_DLY) ? ENTRY_DLY : EXIT_DLY;
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] ENTRY_LOAD = CNT_W'(ENTRY_DLY - 1);
    localparam logic [CNT_W-1:0] EXIT_LOAD  = CNT_W'(EXIT_DLY - 2);

    pwr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             cnt_zero;

    // Delay counter expiry
    always_comb begin
        cnt_zero = (cnt_q == '0);
    end

    // Next-state and counter-load decision
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        case (state_q)
            PS_ACTIVE: begin
                if (pdn_cmd_i) begin
                    state_d = PS_ENTER;
                    cnt_d   = ENTRY_LOAD;
                end
            end
            PS_ENTER: begin
                if (cnt_zero) begin
                    state_d = PS_DOWN;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            PS_DOWN: begin
                if (px_i) begin
                    state_d = PS_EXIT;
                    cnt_d   = EXIT_LOAD;
                end
            end
            PS_EXIT: begin
                if (cnt_zero) begin
                    state_d = PS_ACTIVE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = PS_ACTIVE;
                cnt_d   = '0;
            end
        endcase
    end

    // State and delay counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_ACTIVE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs: current state, and the exit-bit clear on the edge that returns to Active
    always_comb begin
        state_o  = state_q;
        px_clr_o = (state_q == PS_EXIT) && cnt_zero;
    end

endmodule

// File: rtl/pdn_ref_timer.sv
// Internal refresh interval timer. It counts only while enabled, returns to
// zero whenever it is disabled, and gives a one-cycle tick every INTERVAL
// enabled cycles.
// Assumes: INTERVAL >= 2.
module pdn_ref_timer #(
    parameter int unsigned INTERVAL = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);

    localparam int unsigned TW = $clog2(INTERVAL);
    localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

    logic [TW-1:0] cnt_q;
    logic          at_last;

    // Terminal count detect
    always_comb begin
        at_last = (cnt_q == LAST);
        tick_o  = en_i && at_last;
    end

    // Interval counter: held at zero while gated, wraps at the terminal count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en_i || at_last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pdn_ref_addr.sv
// Refresh address counters and strobe output register.
// Bank counter advances on every refresh. The row counter advances on a
// bank wrap for automatic refreshes, or on an external increment command.
// Assumes: auto_i and ext_ok_i are never high together.
module pdn_ref_addr #(
    parameter int unsigned BANK_W = 3,
    parameter int unsigned ROW_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              auto_i,
    input  logic              ext_i,
    input  logic              ext_inc_i,
    input  logic              ext_ok_i,
    output logic              stb_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [ROW_W-1:0]  row_o
);

    localparam logic [BANK_W-1:0] BANK_LAST = {BANK_W{1'b1}};

    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  row_q;
    logic              ext_go;
    logic              fire;
    logic              row_step;

    // Refresh source selection and row advance rule
    always_comb begin
        ext_go = ext_ok_i && (ext_i || ext_inc_i);
        fire   = auto_i || ext_go;
        if (auto_i) begin
            row_step = (bank_q == BANK_LAST);
        end else begin
            row_step = ext_go && ext_inc_i;
        end
    end

    // Address counters: present the current value, then advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
            row_q  <= '0;
        end else if (fire) begin
            bank_q <= bank_q + 1'b1;
            if (row_step) begin
                row_q <= row_q + 1'b1;
            end
        end
    end

    // Strobe and address output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_o  <= 1'b0;
            bank_o <= '0;
            row_o  <= '0;
        end else begin
            stb_o <= fire;
            if (fire) begin
                bank_o <= bank_q;
                row_o  <= row_q;
            end
        end
    end

endmodule

// File: rtl/pdn_refresh_ctrl.sv
// Top of the DRAM powerdown self-refresh controller. It joins the serial
// exit-bit register, the power state sequencer, the gated refresh timer and
// the shared refresh address counters.
// Assumes: request packet decoding upstream produces one-cycle command pulses.
module pdn_refresh_ctrl
    import pdn_refresh_pkg::*;
#(
    parameter int unsigned BANK_W       = 3,
    parameter int unsigned ROW_W        = 12,
    parameter int unsigned CFG_AW       = 8,
    parameter int unsigned CFG_DW       = 8,
    parameter int unsigned ENTRY_DLY    = 4,
    parameter int unsigned EXIT_DLY     = 6,
    parameter int unsigned REF_INTERVAL = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pdn_cmd_i,
    input  logic              ext_ref_i,
    input  logic              ext_ref_inc_i,
    input  logic              cfg_wr_i,
    input  logic [CFG_AW-1:0] cfg_addr_i,
    input  logic [CFG_DW-1:0] cfg_data_i,
    output logic              ref_stb_o,
    output logic [BANK_W-1:0] ref_bank_o,
    output logic [ROW_W-1:0]  ref_row_o,
    output logic              powerdown_o
);

    pwr_state_e fsm_state;
    logic       exit_px;
    logic       px_clr;
    logic       in_down;
    logic       in_active;
    logic       timer_en;
    logic       ref_tick;

    // State decode shared by the sub-blocks
    always_comb begin
        in_down     = (fsm_state == PS_DOWN);
        in_active   = (fsm_state == PS_ACTIVE);
        timer_en    = in_down && !exit_px;
        powerdown_o = (fsm_state == PS_DOWN) || (fsm_state == PS_EXIT);
    end

    pdn_cfg_port #(
        .ADDR_W    (CFG_AW),
        .DATA_W    (CFG_DW),
        .EXIT_ADDR (EXIT_REG_ADDR),
        .EXIT_VAL  (EXIT_REG_VAL)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (cfg_wr_i),
        .addr_i    (cfg_addr_i),
        .data_i    (cfg_data_i),
        .in_down_i (in_down),
        .clr_i     (px_clr),
        .px_o      (exit_px)
    );

    pdn_state_fsm #(
        .ENTRY_DLY (ENTRY_DLY),
        .EXIT_DLY  (EXIT_DLY)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pdn_cmd_i (pdn_cmd_i),
        .px_i      (exit_px),
        .state_o   (fsm_state),
        .px_clr_o  (px_clr)
    );

    pdn_ref_timer #(
        .INTERVAL (REF_INTERVAL)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (timer_en),
        .tick_o (ref_tick)
    );

    pdn_ref_addr #(
        .BANK_W (BANK_W),
        .ROW_W  (ROW_W)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .auto_i    (ref_tick),
        .ext_i     (ext_ref_i),
        .ext_inc_i (ext_ref_inc_i),
        .ext_ok_i  (in_active),
        .stb_o     (ref_stb_o),
        .bank_o    (ref_bank_o),
        .row_o     (ref_row_o)
    );

endmodule

// File: rtl/pdn_refresh_chk.sv
// Assertion checker for pdn_refresh_ctrl, attached with bind.
// Assumes: it sees the sequencer state, the exit bit, the timer tick and the
// internal address counters through the bind connections.
module pdn_refresh_chk
    import pdn_refresh_pkg::*;
#(
    parameter int unsigned BANK_W = 3,
    parameter int unsigned ROW_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pdn_cmd_i,
    input  logic              ref_stb_o,
    input  logic [BANK_W-1:0] ref_bank_o,
    input  logic [ROW_W-1:0]  ref_row_o,
    input  logic              powerdown_o,
    input  pwr_state_e        state,
    input  logic              px,
    input  logic              tick,
    input  logic [BANK_W-1:0] bank_q,
    input  logic [ROW_W-1:0]  row_q
);

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_ACTIVE) && !pdn_cmd_i |=> (state == PS_ACTIVE));  // R2

    AST_DOWN_NO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        powerdown_o && !tick |=> !ref_stb_o);  // R3

    AST_ENTER_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_ENTER) && ($past(state) == PS_ENTER) |-> !ref_stb_o);  // R3

    AST_TICK_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> ref_stb_o);  // R4

    AST_BANK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ref_stb_o |-> (bank_q == ref_bank_o + 1'b1));  // R5

    AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ref_stb_o && powerdown_o && (ref_bank_o == '1) |-> (row_q == ref_row_o + 1'b1));  // R6

    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ref_stb_o && powerdown_o && (ref_bank_o != '1) |-> (row_q == ref_row_o));  // R6

    AST_DOWN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_DOWN) && !px |=> (state == PS_DOWN));  // R10

    AST_EXIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_EXIT) |-> !ref_stb_o);  // R11

    AST_PX_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(powerdown_o) |-> !px);  // R12

endmodule

bind pdn_refresh_ctrl pdn_refresh_chk #(
    .BANK_W (BANK_W),
    .ROW_W  (ROW_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pdn_cmd_i   (pdn_cmd_i),
    .ref_stb_o   (ref_stb_o),
    .ref_bank_o  (ref_bank_o),
    .ref_row_o   (ref_row_o),
    .powerdown_o (powerdown_o),
    .state       (fsm_state),
    .px          (exit_px),
    .tick        (ref_tick),
    .bank_q      (u_addr.bank_q),
    .row_q       (u_addr.row_q)
);

// File: tb/pdn_refresh_ctrl_test.sv
// Self-checking bench on a reduced configuration (8 banks, 8 rows).
module pdn_refresh_ctrl_test;

    localparam int BW = 3;
    localparam int RW = 3;
    localparam int ED = 4;
    localparam int XD = 6;
    localparam int RI = 5;
    localparam int NB = 1 << BW;
    localparam int NR = 1 << RW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          pdn_cmd_i;
    logic          ext_ref_i;
    logic          ext_ref_inc_i;
    logic          cfg_wr_i;
    logic [7:0]    cfg_addr_i;
    logic [7:0]    cfg_data_i;
    logic          ref_stb_o;
    logic [BW-1:0] ref_bank_o;
    logic [RW-1:0] ref_row_o;
    logic          powerdown_o;

    int n_chk  = 0;
    int n_fail = 0;
    int eb     = 0;
    int er     = 0;

    always #10 clk = ~clk;

    pdn_refresh_ctrl #(
        .BANK_W       (BW),
        .ROW_W        (RW),
        .CFG_AW       (8),
        .CFG_DW       (8),
        .ENTRY_DLY    (ED),
        .EXIT_DLY     (XD),
        .REF_INTERVAL (RI)
    ) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .pdn_cmd_i     (pdn_cmd_i),
        .ext_ref_i     (ext_ref_i),
        .ext_ref_inc_i (ext_ref_inc_i),
        .cfg_wr_i      (cfg_wr_i),
        .cfg_addr_i    (cfg_addr_i),
        .cfg_data_i    (cfg_data_i),
        .ref_stb_o     (ref_stb_o),
        .ref_bank_o    (ref_bank_o),
        .ref_row_o     (ref_row_o),
        .powerdown_o   (powerdown_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // External refresh pulse; checks strobe, address and one-cycle width
    task automatic ext_pulse(input bit inc);
        if (inc) ext_ref_inc_i = 1'b1;
        else     ext_ref_i     = 1'b1;
        @(negedge clk);
        ext_ref_i     = 1'b0;
        ext_ref_inc_i = 1'b0;
        chk(inc ? "R8 ext strobe" : "R7 ext strobe", int'(ref_stb_o), 1);
        chk(inc ? "R8 ext bank" : "R7 ext bank", int'(ref_bank_o), eb);
        chk(inc ? "R8 ext row" : "R7 ext row", int'(ref_row_o), er);
        eb = (eb + 1) % NB;
        if (inc) er = (er + 1) % NR;
        @(negedge clk);
        chk("R7 strobe one cycle", int'(ref_stb_o), 0);
    endtask

    // Powerdown command with an external refresh during the entry delay
    task automatic enter_pdn();
        int k;
        int s;
        pdn_cmd_i = 1'b1;
        @(negedge clk);
        pdn_cmd_i = 1'b0;
        ext_ref_i = 1'b1;
        k = 1;
        s = 0;
        while (!powerdown_o && k < 50) begin
            @(negedge clk);
            ext_ref_i = 1'b0;
            if (ref_stb_o) s++;
            k++;
        end
        // rise after the ED-th edge following the sampling edge
        chk("R2 entry delay", k, ED + 1);
        chk("R3 no strobe during entry", s, 0);
    endtask

    // Run n automatic refreshes; on strobe 1 inject ignored commands and writes
    task automatic auto_run(input int n);
        for (int i = 0; i < n; i++) begin
            int j;
            int drop;
            j = 0;
            drop = 0;
            do begin
                @(negedge clk);
                j++;
                if (!powerdown_o) drop++;
                if (i == 1 && j == 1) begin
                    ext_ref_inc_i = 1'b1;
                    pdn_cmd_i     = 1'b1;
                    cfg_wr_i      = 1'b1;
                    cfg_addr_i    = 8'h03;
                    cfg_data_i    = 8'h02;
                end else if (i == 1 && j == 2) begin
                    ext_ref_inc_i = 1'b0;
                    pdn_cmd_i     = 1'b0;
                    cfg_addr_i    = 8'h02;
                    cfg_data_i    = 8'h01;
                end else if (i == 1 && j == 3) begin
                    cfg_wr_i = 1'b0;
                end
            end while (!ref_stb_o && j < 100);
            chk("R4 refresh spacing", j, RI);
            chk("R5 auto bank", int'(ref_bank_o), eb);
            chk("R6 auto row", int'(ref_row_o), er);
            chk("R10 R12 held in powerdown", drop, 0);
            eb++;
            if (eb == NB) begin
                eb = 0;
                er = (er + 1) % NR;
            end
        end
    endtask

    // Exit write right after a strobe; measures the exit delay
    task automatic exit_pdn();
        int k;
        int s;
        cfg_wr_i   = 1'b1;
        cfg_addr_i = 8'h03;
        cfg_data_i = 8'h01;
        @(negedge clk);
        cfg_wr_i = 1'b0;
        k = 1;
        s = 0;
        while (powerdown_o && k < 50) begin
            @(negedge clk);
            k++;
            if (ref_stb_o) s++;
        end
        chk("R9 exit delay", k, XD + 1);
        chk("R11 no strobe during exit", s, 0);
    endtask

    initial begin
        rst_n         = 1'b0;
        pdn_cmd_i     = 1'b0;
        ext_ref_i     = 1'b0;
        ext_ref_inc_i = 1'b0;
        cfg_wr_i      = 1'b0;
        cfg_addr_i    = 8'h00;
        cfg_data_i    = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset powerdown", int'(powerdown_o), 0);
        chk("R1 reset strobe", int'(ref_stb_o), 0);
        chk("R1 reset bank", int'(ref_bank_o), 0);
        chk("R1 reset row", int'(ref_row_o), 0);

        // R7: bank wraps without moving the row
        for (int i = 0; i < NB + 2; i++) ext_pulse(1'b0);
        // R8: row increments with each command
        for (int i = 0; i < 3; i++) ext_pulse(1'b1);

        enter_pdn();
        auto_run(NB * NR + 3);
        exit_pdn();
        ext_pulse(1'b0);

        // R10: exit write in Active must not latch; R12: re-entry holds
        cfg_wr_i   = 1'b1;
        cfg_addr_i = 8'h03;
        cfg_data_i = 8'h01;
        @(negedge clk);
        cfg_wr_i = 1'b0;
        @(negedge clk);
        chk("R10 write in active ignored", int'(powerdown_o), 0);
        enter_pdn();
        auto_run(4);
        exit_pdn();
        ext_pulse(1'b1);
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
    end

endmodule